// File: doc/BRIEF.md
# Clock Ratio Selection Datapath

This block turns a set of stored clock-ratio words into the control word that steers a fractional-N frequency synthesizer. Software writes up to four ratio words into a small register bank. One word is chosen by either a static select field or a lock-clock select field, depending on the ratio mode. In dynamic mode that word may be read in a low-frequency fixed-point format. An optional power-of-two modifier then scales it, and the result is corrected for the reference input divider. The outcome is the static effective ratio.

A digital PLL outside the block delivers a dynamic ratio over a valid/ready stream. The block always accepts it: `dpll_ready` is held high and is never used to push back. It keeps the most recent accepted word. The final fractional-N word is either that dynamic ratio or the static effective ratio. The choice comes from a manual source bit, or in automatic mode from a detector that watches a reference clock input for activity. The output is registered. It carries a one-cycle strobe whenever its value changes, and the strobe is not back-pressured: the synthesizer must take every update.

Top module: `ratio_fracn_ctrl`

## Requirements
- R1: After reset, `fracn_word` is 0 and `fracn_valid`, `clk_present` and `src_is_dyn` are low.
- R2: A write with `cfg_we` high stores `cfg_wdata` into ratio slot `cfg_idx` (0 to 3). With `dyn_mode` low, `sel_static` picks the slot and `sel_lock` has no effect.
- R3: With `dyn_mode` high, `sel_lock` picks the slot and `sel_static` has no effect.
- R4: Ratios are unsigned 12.20 fixed point. When `dyn_mode` and `lf_fmt` are both high, the stored word is read as 20.12 and converted to 12.20 by a left shift of 8. With `dyn_mode` low, `lf_fmt` has no effect.
- R5: With `mod_en` high, `mod_code` scales the ratio. The codes are 000 ×1, 001 ×2, 010 ×4, 011 ×8, 100 ÷2, 101 ÷4, 110 ÷8 and 111 ÷16, and divisions truncate. With `mod_en` low, `mod_code` has no effect.
- R6: The modified ratio is multiplied by the reference divide factor. The `refdiv_code` values are 00 ×4, 01 ×2, and 10 or 11 ×1.
- R7: Any left shift that would lose a set bit out of the 32-bit word gives 0xFFFFFFFF.
- R8: With `src_auto` low, `src_manual_dyn` high selects the dynamic ratio and low selects the static effective ratio. `src_is_dyn` shows the choice.
- R9: `dpll_ready` is always high. A word on `dpll_ratio` is taken only in a cycle where `dpll_valid` is high, and the last word taken is held.
- R10: `clk_present` rises once 4 consecutive synchronized rising edges of `ref_sense` have each come within 256 cycles of the previous one. It falls once 256 cycles pass with no edge.
- R11: With `src_auto` high, the dynamic ratio is used exactly when `clk_present` is high.
- R12: `fracn_word` updates one clock after its inputs change. `fracn_valid` is high for exactly the cycles in which `fracn_word` took a new, different value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Ratio slot write enable |
| cfg_idx | input | 2 | Ratio slot index for a write |
| cfg_wdata | input | 32 | Ratio word to write |
| sel_static | input | 2 | Slot select used in static ratio mode |
| sel_lock | input | 2 | Slot select used in dynamic ratio mode |
| dyn_mode | input | 1 | 1 = dynamic ratio mode |
| lf_fmt | input | 1 | 20.12 format select (dynamic mode only) |
| mod_en | input | 1 | Enable ratio modifier |
| mod_code | input | 3 | Modifier code |
| refdiv_code | input | 2 | Reference input divider setting |
| src_auto | input | 1 | 1 = source follows clock presence |
| src_manual_dyn | input | 1 | Manual source: 1 = dynamic ratio |
| dpll_valid | input | 1 | Dynamic ratio valid |
| dpll_ready | output | 1 | Dynamic ratio ready (always high) |
| dpll_ratio | input | 32 | Dynamic ratio from the digital PLL |
| ref_sense | input | 1 | Asynchronous reference clock for presence sensing |
| fracn_word | output | 32 | Registered fractional-N control word |
| fracn_valid | output | 1 | One-cycle strobe on each change of fracn_word |
| clk_present | output | 1 | Reference clock detected |
| src_is_dyn | output | 1 | Registered source choice, 1 = dynamic |

## Verification
A new dynamic word from the PLL and a change to the static selection can land in the same clock while the dynamic source is active. The bench drives both on one falling edge. It then checks that the output takes only the dynamic word with a single strobe. After that, it switches to the static source and checks that the new static selection appears. A second clash is a ratio write to the slot that is currently selected, made together with a change of modifier code. The output must then reflect the new word and the new scaling together, one cycle after the written value lands.

// File: rtl/ratio_fracn_pkg.sv
package ratio_fracn_pkg;
  localparam int unsigned RW = 32;
  typedef logic [RW-1:0] ratio_t;

  typedef enum logic [1:0] {
    DIV_BY4 = 2'b00,
    DIV_BY2 = 2'b01,
    DIV_BY1 = 2'b10,
    DIV_BY1_ALT = 2'b11
  } refdiv_e;

  // Left shift with saturation: any set bit pushed out gives all ones.
  function automatic ratio_t shl_sat(input ratio_t x, input logic [3:0] k);
    logic [2*RW-1:0] wide;
    wide = {{RW{1'b0}}, x} << k;
    return (|wide[2*RW-1:RW]) ? '1 : wide[RW-1:0];
  endfunction
endpackage

// File: rtl/ratio_bank.sv
module ratio_bank
  import ratio_fracn_pkg::*;
#(
  parameter int unsigned N_RATIO  = 4,
  parameter int unsigned LF_SHIFT = 8,
  localparam int unsigned IDX_W   = $clog2(N_RATIO)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  ratio_t           wdata,
  input  logic [IDX_W-1:0] sel_static,
  input  logic [IDX_W-1:0] sel_lock,
  input  logic             dyn_mode,
  input  logic             lf_fmt,
  output ratio_t           canon
);
  ratio_t             slots [N_RATIO];
  logic [IDX_W-1:0]   pick;
  ratio_t             raw;

  for (genvar gi = 0; gi < N_RATIO; gi++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              slots[gi] <= '0;
      else if (we && (widx == IDX_W'(gi)))     slots[gi] <= wdata;
    end
  end

  always_comb begin
    pick  = dyn_mode ? sel_lock : sel_static;
    raw   = slots[pick];
    canon = (dyn_mode && lf_fmt) ? shl_sat(raw, 4'(LF_SHIFT)) : raw;
  end
endmodule

// File: rtl/ratio_scaler.sv
module ratio_scaler
  import ratio_fracn_pkg::*;
(
  input  ratio_t      ratio_in,
  input  logic        mod_en,
  input  logic [2:0]  mod_code,
  input  logic [1:0]  refdiv_code,
  output ratio_t      eff_out
);
  ratio_t modded;

  always_comb begin
    if (!mod_en)
      modded = ratio_in;
    else if (!mod_code[2])
      modded = shl_sat(ratio_in, {2'b00, mod_code[1:0]});
    else
      modded = ratio_in >> ({2'b00, mod_code[1:0]} + 4'd1);
  end

  always_comb begin
    unique case (refdiv_e'(refdiv_code))
      DIV_BY4: eff_out = shl_sat(modded, 4'd2);
      DIV_BY2: eff_out = shl_sat(modded, 4'd1);
      default: eff_out = modded;
    endcase
  end
endmodule

// File: rtl/clk_sense.sv
module clk_sense #(
  parameter int unsigned WINDOW      = 256,
  parameter int unsigned NEED_EDGES  = 4,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned GAP_W      = $clog2(WINDOW),
  localparam int unsigned RUN_W      = $clog2(NEED_EDGES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_async,
  output logic present
);
  logic [SYNC_STAGES:0] sync_q;
  logic [GAP_W-1:0]     gap_q;
  logic [RUN_W-1:0]     run_q;
  logic                 rise;

  assign rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-1:0], ref_async};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q   <= '0;
      run_q   <= '0;
      present <= 1'b0;
    end else if (rise) begin
      gap_q <= '0;
      if (run_q < RUN_W'(NEED_EDGES)) run_q <= run_q + 1'b1;
      if (run_q >= RUN_W'(NEED_EDGES - 1)) present <= 1'b1;
    end else if (gap_q == GAP_W'(WINDOW - 1)) begin
      run_q   <= '0;
      present <= 1'b0;
    end else begin
      gap_q <= gap_q + 1'b1;
    end
  end
endmodule

// File: rtl/src_out.sv
module src_out
  import ratio_fracn_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  ratio_t static_eff,
  input  logic   dyn_take,
  input  ratio_t dyn_word,
  input  logic   src_auto,
  input  logic   src_manual_dyn,
  input  logic   present,
  output ratio_t word_q,
  output logic   strobe_q,
  output logic   src_dyn_q
);
  ratio_t dyn_hold;
  ratio_t nxt;
  logic   use_dyn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dyn_hold <= '0;
    else if (dyn_take) dyn_hold <= dyn_word;
  end

  always_comb begin
    use_dyn = src_auto ? present : src_manual_dyn;
    nxt     = use_dyn ? dyn_hold : static_eff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q    <= '0;
      strobe_q  <= 1'b0;
      src_dyn_q <= 1'b0;
    end else begin
      word_q    <= nxt;
      strobe_q  <= (nxt != word_q);
      src_dyn_q <= use_dyn;
    end
  end
endmodule

// File: rtl/ratio_fracn_ctrl.sv
module ratio_fracn_ctrl
  import ratio_fracn_pkg::*;
#(
  parameter int unsigned WINDOW     = 256,
  parameter int unsigned NEED_EDGES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_idx,
  input  logic [31:0] cfg_wdata,
  input  logic [1:0]  sel_static,
  input  logic [1:0]  sel_lock,
  input  logic        dyn_mode,
  input  logic        lf_fmt,
  input  logic        mod_en,
  input  logic [2:0]  mod_code,
  input  logic [1:0]  refdiv_code,
  input  logic        src_auto,
  input  logic        src_manual_dyn,
  input  logic        dpll_valid,
  output logic        dpll_ready,
  input  logic [31:0] dpll_ratio,
  input  logic        ref_sense,
  output logic [31:0] fracn_word,
  output logic        fracn_valid,
  output logic        clk_present,
  output logic        src_is_dyn
);
  ratio_t canon;
  ratio_t static_eff;

  assign dpll_ready = 1'b1;

  ratio_bank #(.N_RATIO(4), .LF_SHIFT(8)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .widx(cfg_idx), .wdata(cfg_wdata),
    .sel_static(sel_static), .sel_lock(sel_lock), .dyn_mode(dyn_mode),
    .lf_fmt(lf_fmt), .canon(canon)
  );

  ratio_scaler u_scale (
    .ratio_in(canon), .mod_en(mod_en), .mod_code(mod_code),
    .refdiv_code(refdiv_code), .eff_out(static_eff)
  );

  clk_sense #(.WINDOW(WINDOW), .NEED_EDGES(NEED_EDGES)) u_sense (
    .clk(clk), .rst_n(rst_n), .ref_async(ref_sense), .present(clk_present)
  );

  src_out u_out (
    .clk(clk), .rst_n(rst_n), .static_eff(static_eff),
    .dyn_take(dpll_valid & dpll_ready), .dyn_word(dpll_ratio),
    .src_auto(src_auto), .src_manual_dyn(src_manual_dyn), .present(clk_present),
    .word_q(fracn_word), .strobe_q(fracn_valid), .src_dyn_q(src_is_dyn)
  );
endmodule

// File: rtl/ratio_fracn_ctrl_chk.sv
module ratio_fracn_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ref_sense,
  input logic        src_auto,
  input logic [31:0] fracn_word,
  input logic        fracn_valid,
  input logic        clk_present,
  input logic        src_is_dyn
);
  logic [9:0] idle_cnt;
  logic       ref_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt <= '0;
      ref_d    <= 1'b0;
    end else begin
      ref_d <= ref_sense;
      if (ref_sense != ref_d) idle_cnt <= '0;
      else if (idle_cnt != '1) idle_cnt <= idle_cnt + 1'b1;
    end
  end

  // R12
  strobe_means_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fracn_valid |-> (fracn_word != $past(fracn_word)));

  // R12
  quiet_means_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fracn_valid |-> $stable(fracn_word));

  // R10
  idle_means_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_cnt >= 10'd300) |-> !clk_present);

  // R10
  rise_needs_activity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_present) |-> (idle_cnt < 10'd16));

  // R11
  auto_follows_presence_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(src_auto) && src_auto && $stable(clk_present)) |-> (src_is_dyn == clk_present));
endmodule

bind ratio_fracn_ctrl ratio_fracn_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ref_sense(ref_sense), .src_auto(src_auto),
  .fracn_word(fracn_word), .fracn_valid(fracn_valid),
  .clk_present(clk_present), .src_is_dyn(src_is_dyn)
);

// File: tb/ratio_fracn_ctrl_tb_top.sv
module ratio_fracn_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic [1:0]  sel_static = '0, sel_lock = '0;
  logic        dyn_mode = 1'b0, lf_fmt = 1'b0, mod_en = 1'b0;
  logic [2:0]  mod_code = '0;
  logic [1:0]  refdiv_code = 2'b10;
  logic        src_auto = 1'b0, src_manual_dyn = 1'b0;
  logic        dpll_valid = 1'b0;
  logic        dpll_ready;
  logic [31:0] dpll_ratio = '0;
  logic        ref_sense = 1'b0;
  logic [31:0] fracn_word;
  logic        fracn_valid, clk_present, src_is_dyn;
  logic        ref_run = 1'b0;

  int checks = 0;
  int errors = 0;
  logic [31:0] slot_m [4];

  always #4 clk = ~clk;

  initial forever begin
    @(posedge clk);
    if (ref_run) begin
      repeat (3) @(posedge clk);
      ref_sense = ~ref_sense;
    end
  end

  ratio_fracn_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .sel_static(sel_static), .sel_lock(sel_lock), .dyn_mode(dyn_mode), .lf_fmt(lf_fmt),
    .mod_en(mod_en), .mod_code(mod_code), .refdiv_code(refdiv_code), .src_auto(src_auto),
    .src_manual_dyn(src_manual_dyn), .dpll_valid(dpll_valid), .dpll_ready(dpll_ready),
    .dpll_ratio(dpll_ratio), .ref_sense(ref_sense), .fracn_word(fracn_word),
    .fracn_valid(fracn_valid), .clk_present(clk_present), .src_is_dyn(src_is_dyn)
  );

  function automatic logic [31:0] sat_up(logic [31:0] x, int k);
    logic [63:0] w;
    w = {32'b0, x} << k;
    return (w[63:32] != 0) ? 32'hFFFF_FFFF : w[31:0];
  endfunction

  function automatic logic [31:0] model_static();
    logic [31:0] v;
    v = slot_m[dyn_mode ? sel_lock : sel_static];
    if (dyn_mode && lf_fmt) v = sat_up(v, 8);
    if (mod_en) begin
      if (mod_code < 3'd4) v = sat_up(v, int'(mod_code));
      else                 v = v >> (int'(mod_code) - 3);
    end
    if (refdiv_code == 2'b00)      v = sat_up(v, 2);
    else if (refdiv_code == 2'b01) v = sat_up(v, 1);
    return v;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(int idx, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_wdata = d;
    slot_m[idx] = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 word", fracn_word, 32'h0);
    chk("R1 valid", {31'b0, fracn_valid}, 32'h0);
    chk("R1 present", {31'b0, clk_present}, 32'h0);
    chk("R1 src", {31'b0, src_is_dyn}, 32'h0);
    chk("R9 ready", {31'b0, dpll_ready}, 32'h1);
  endtask

  task automatic t_static_sel();
    wr(0, 32'h0010_0000); wr(1, 32'h0023_4567); wr(2, 32'h0AB0_0001); wr(3, 32'h0000_1234);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); sel_static = 2'(i); sel_lock = 2'(3 - i);
      settle();
      chk("R2 static select", fracn_word, slot_m[i]);
    end
  endtask

  task automatic t_dyn_sel();
    @(negedge clk); dyn_mode = 1'b1; sel_static = 2'd0; sel_lock = 2'd2;
    settle();
    chk("R3 lock select", fracn_word, slot_m[2]);
    @(negedge clk); sel_static = 2'd3;
    settle();
    chk("R3 static select ignored", fracn_word, slot_m[2]);
    @(negedge clk); sel_lock = 2'd1; lf_fmt = 1'b1;
    settle();
    chk("R4 20.12 read", fracn_word, 32'h2345_6700);
    @(negedge clk); sel_lock = 2'd2;
    settle();
    chk("R7 format overflow", fracn_word, 32'hFFFF_FFFF);
    @(negedge clk); dyn_mode = 1'b0; sel_static = 2'd1;
    settle();
    chk("R4 lf ignored in static", fracn_word, slot_m[1]);
    @(negedge clk); lf_fmt = 1'b0;
  endtask

  task automatic t_modifier();
    @(negedge clk); sel_static = 2'd3; mod_en = 1'b0; mod_code = 3'd7;
    settle();
    chk("R5 modifier disabled", fracn_word, slot_m[3]);
    for (int c = 0; c < 8; c++) begin
      @(negedge clk); mod_en = 1'b1; mod_code = 3'(c);
      settle();
      chk("R5 modifier code", fracn_word, model_static());
    end
    @(negedge clk); mod_code = 3'd7;
    settle();
    chk("R5 div16", fracn_word, 32'h0000_0123);
    @(negedge clk); mod_en = 1'b0;
  endtask

  task automatic t_refdiv();
    @(negedge clk); sel_static = 2'd0; refdiv_code = 2'b00;
    settle();
    chk("R6 div4 corr", fracn_word, 32'h0040_0000);
    @(negedge clk); refdiv_code = 2'b01;
    settle();
    chk("R6 div2 corr", fracn_word, 32'h0020_0000);
    @(negedge clk); refdiv_code = 2'b11;
    settle();
    chk("R6 div1 corr", fracn_word, 32'h0010_0000);
    wr(0, 32'h8000_0000);
    @(negedge clk); mod_en = 1'b1; mod_code = 3'd1;
    settle();
    chk("R7 modifier sat", fracn_word, 32'hFFFF_FFFF);
    @(negedge clk); mod_en = 1'b0; refdiv_code = 2'b00;
    settle();
    chk("R7 divider sat", fracn_word, 32'hFFFF_FFFF);
    @(negedge clk); refdiv_code = 2'b10;
    wr(0, 32'h0010_0000);
    @(negedge clk);
  endtask

  task automatic t_strobe();
    @(negedge clk); sel_static = 2'd1;
    settle();
    @(negedge clk); sel_static = 2'd3;
    @(negedge clk);
    chk("R12 strobe on change", {31'b0, fracn_valid}, 32'h1);
    chk("R12 one cycle latency", fracn_word, slot_m[3]);
    @(negedge clk);
    chk("R12 strobe single", {31'b0, fracn_valid}, 32'h0);
    wr(2, slot_m[3]);
    @(negedge clk); sel_static = 2'd2;
    @(negedge clk);
    chk("R12 no strobe same value", {31'b0, fracn_valid}, 32'h0);
    // clash: write to the selected slot together with a modifier change
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 2'd2; cfg_wdata = 32'h0000_4000; slot_m[2] = 32'h0000_4000;
    mod_en = 1'b1; mod_code = 3'd2;
    @(negedge clk); cfg_we = 1'b0;
    @(negedge clk);
    chk("R12 write with modifier", fracn_word, 32'h0001_0000);
    @(negedge clk); mod_en = 1'b0;
    settle();
  endtask

  task automatic t_manual_src();
    @(negedge clk); dpll_ratio = 32'h0055_AA00; dpll_valid = 1'b0; src_manual_dyn = 1'b1;
    settle();
    chk("R9 no take without valid", fracn_word, 32'h0);
    chk("R8 src flag", {31'b0, src_is_dyn}, 32'h1);
    @(negedge clk); dpll_valid = 1'b1;
    @(negedge clk); dpll_valid = 1'b0; dpll_ratio = 32'h1111_1111;
    @(negedge clk);
    chk("R9 take with valid", fracn_word, 32'h0055_AA00);
    settle();
    chk("R9 hold last", fracn_word, 32'h0055_AA00);
    // clash: new dynamic word together with a static selection change
    @(negedge clk); dpll_valid = 1'b1; dpll_ratio = 32'h0077_0000; sel_static = 2'd0;
    @(negedge clk); dpll_valid = 1'b0;
    @(negedge clk);
    chk("R8 dynamic wins", fracn_word, 32'h0077_0000);
    @(negedge clk); src_manual_dyn = 1'b0;
    settle();
    chk("R8 back to static", fracn_word, slot_m[0]);
    chk("R8 static flag", {31'b0, src_is_dyn}, 32'h0);
  endtask

  task automatic t_auto_src();
    @(negedge clk); src_auto = 1'b1; src_manual_dyn = 1'b1;
    settle();
    chk("R11 absent static", fracn_word, slot_m[0]);
    ref_run = 1'b1;
    repeat (12) @(negedge clk);
    chk("R10 not yet present", {31'b0, clk_present}, 32'h0);
    repeat (60) @(negedge clk);
    chk("R10 present", {31'b0, clk_present}, 32'h1);
    chk("R11 present dynamic", fracn_word, 32'h0077_0000);
    ref_run = 1'b0;
    repeat (200) @(negedge clk);
    chk("R10 still present in window", {31'b0, clk_present}, 32'h1);
    repeat (120) @(negedge clk);
    chk("R10 absent after idle", {31'b0, clk_present}, 32'h0);
    chk("R11 absent back to static", fracn_word, slot_m[0]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) slot_m[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_static_sel();
    t_dyn_sel();
    t_modifier();
    t_refdiv();
    t_strobe();
    t_manual_src();
    t_auto_src();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule